// File: doc/BRIEF.md
# Banked register access unit

This block keeps the mode-specific copies of the stack pointer, link register, saved status word and the shadow high registers of a processor with several privilege modes. Privileged software reaches them through explicit requests that name a target mode and a register number. The running mode plays no part in selecting storage, so a supervisor handler can, for instance, reach the interrupt-mode stack pointer directly.

Every request goes through a legality matrix first. The outcome depends on the current mode, the target mode and the register number. A forbidden combination produces a one-cycle undefined-instruction pulse and changes nothing. A legal write updates exactly one storage word. A legal read returns that word one cycle after the request, together with a valid strobe. Exception entry, instruction decode and the ordinary unbanked register file are handled elsewhere.

Top module: `bnk_regs_top`

## Requirements
- R1: An active-low reset clears every stored word to zero and holds rd_valid and undef_exc low. After reset, a legal read of any slot returns 0.
- R2: Every request whose target mode equals the current mode is illegal.
- R3: With user mode (0x10) as target, registers 8 to 12 are legal only when the current mode is FIQ (0x11).
- R4: With user mode as target, register 13 is illegal when the current mode is system (0x1F). Register 14 is illegal when the current mode is hyp (0x1A) or system.
- R5: With hyp mode as target, register 17 is legal only from hyp or monitor (0x16), and every other register number is legal only from monitor. Because R2 also applies, hyp-to-hyp is illegal.
- R6: Register 16 selects the saved status word of the target bank, and 13 and 14 select that bank's stack pointer and link register. The other mode codes are IRQ 0x12, supervisor 0x13, abort 0x17 and undefined 0x1B. User and system share one bank, so a word written with either as target is read back with the other.
- R7: Registers 8 to 12 have exactly two independent copies, one for user and one for FIQ, and each copy holds five distinct words.
- R8: Register 17 addresses a single hyp exception link word.
- R9: The following combinations are illegal:
  - a target mode outside the nine listed codes;
  - a register number outside {8..14, 16, 17};
  - registers 8 to 12 with any target other than user or FIQ;
  - register 16 with user or system as target;
  - register 17 with any target other than hyp.
- R10: An illegal request writes no storage and leaves rd_data unchanged.
- R11: The result appears one cycle after the request is sampled.
  - A legal read raises rd_valid with the data.
  - An illegal request raises undef_exc alone.
  - A legal write raises neither.
  - rd_valid and undef_exc are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_tgt_mode | input | 5 | Target mode code |
| req_regno | input | 5 | Register number |
| req_wdata | input | 32 | Write data |
| cur_mode | input | 5 | Mode the processor is running in |
| rd_valid | output | 1 | Legal read result valid |
| rd_data | output | 32 | Read result, held between legal reads |
| undef_exc | output | 1 | Undefined-instruction pulse for an illegal request |

## Verification
A corrupted or misrouted storage word is not visible on its own. It shows on rd_data only when a legal read reaches that slot, one cycle after the request. The bench therefore writes distinct values into neighbouring banks and copies and reads each one back, and it re-reads a slot after each illegal write aimed at it. A wrong legality decision shows one cycle after the request as undef_exc and rd_valid having swapped, so each matrix entry is driven individually and both strobes are compared.

// File: rtl/bnk_pkg.sv
package bnk_pkg;

  localparam int unsigned MODE_W = 5;
  localparam int unsigned REGN_W = 5;

  localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MODE_MON = 5'h16;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MODE_HYP = 5'h1A;
  localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'h1F;

  localparam logic [REGN_W-1:0] RN_SP   = 5'd13;
  localparam logic [REGN_W-1:0] RN_LR   = 5'd14;
  localparam logic [REGN_W-1:0] RN_SPSR = 5'd16;
  localparam logic [REGN_W-1:0] RN_ELR  = 5'd17;

  typedef enum logic [2:0] {
    K_HI   = 3'd0,
    K_SP   = 3'd1,
    K_LR   = 3'd2,
    K_SPSR = 3'd3,
    K_ELR  = 3'd4
  } slot_kind_t;

  function automatic logic mode_known(input logic [MODE_W-1:0] m);
    case (m)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC, MODE_MON,
      MODE_ABT, MODE_HYP, MODE_UND, MODE_SYS: mode_known = 1'b1;
      default:                                mode_known = 1'b0;
    endcase
  endfunction

  function automatic logic [2:0] mode_bank(input logic [MODE_W-1:0] m);
    case (m)
      MODE_HYP: mode_bank = 3'd1;
      MODE_IRQ: mode_bank = 3'd2;
      MODE_SVC: mode_bank = 3'd3;
      MODE_ABT: mode_bank = 3'd4;
      MODE_UND: mode_bank = 3'd5;
      MODE_MON: mode_bank = 3'd6;
      MODE_FIQ: mode_bank = 3'd7;
      default:  mode_bank = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/bnk_legal.sv
module bnk_legal
  import bnk_pkg::*;
#(
  parameter int unsigned HI_FIRST = 8,
  parameter int unsigned HI_CNT   = 5,
  localparam int unsigned HI_IDX_W = (HI_CNT > 1) ? $clog2(HI_CNT) : 1
) (
  input  logic [MODE_W-1:0]   tgt_mode,
  input  logic [REGN_W-1:0]   regno,
  input  logic [MODE_W-1:0]   cur_mode,
  output logic                legal,
  output slot_kind_t          kind,
  output logic [2:0]          bank,
  output logic [HI_IDX_W-1:0] hi_idx,
  output logic                hi_fiq
);

  logic is_hi;
  logic base_ok;

  assign is_hi  = (32'(regno) >= HI_FIRST) && (32'(regno) < HI_FIRST + HI_CNT);
  assign bank   = mode_bank(tgt_mode);
  assign hi_idx = HI_IDX_W'(32'(regno) - HI_FIRST);
  assign hi_fiq = (tgt_mode == MODE_FIQ);

  // which slot the number selects and whether the target can own it
  always_comb begin
    kind    = K_SP;
    base_ok = 1'b0;
    if (is_hi) begin
      kind    = K_HI;
      base_ok = (tgt_mode == MODE_USR) || (tgt_mode == MODE_FIQ);
    end else begin
      case (regno)
        RN_SP:   begin kind = K_SP;   base_ok = 1'b1; end
        RN_LR:   begin kind = K_LR;   base_ok = 1'b1; end
        RN_SPSR: begin
          kind    = K_SPSR;
          base_ok = (tgt_mode != MODE_USR) && (tgt_mode != MODE_SYS);
        end
        RN_ELR:  begin kind = K_ELR;  base_ok = (tgt_mode == MODE_HYP); end
        default: begin kind = K_SP;   base_ok = 1'b0; end
      endcase
    end
  end

  // current-mode dependent matrix
  always_comb begin
    legal = base_ok && mode_known(tgt_mode) && (tgt_mode != cur_mode);
    if (tgt_mode == MODE_USR) begin
      if (is_hi && cur_mode != MODE_FIQ)                          legal = 1'b0;
      if (regno == RN_SP && cur_mode == MODE_SYS)                 legal = 1'b0;
      if (regno == RN_LR && (cur_mode == MODE_HYP || cur_mode == MODE_SYS))
                                                                  legal = 1'b0;
    end
    if (tgt_mode == MODE_HYP) begin
      if (regno == RN_ELR) begin
        if (cur_mode != MODE_HYP && cur_mode != MODE_MON)         legal = 1'b0;
      end else if (cur_mode != MODE_MON)                          legal = 1'b0;
    end
  end

endmodule

// File: rtl/bnk_store.sv
module bnk_store
  import bnk_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned HI_CNT    = 5,
  localparam int unsigned HI_IDX_W = (HI_CNT > 1) ? $clog2(HI_CNT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  slot_kind_t          kind,
  input  logic [2:0]          bank,
  input  logic [HI_IDX_W-1:0] hi_idx,
  input  logic                hi_fiq,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata
);

  logic [DATA_W-1:0] sp_q   [NUM_BANKS];
  logic [DATA_W-1:0] lr_q   [NUM_BANKS];
  logic [DATA_W-1:0] spsr_q [NUM_BANKS];
  logic [DATA_W-1:0] hi_q   [2][HI_CNT];
  logic [DATA_W-1:0] elr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        sp_q[b]   <= '0;
        lr_q[b]   <= '0;
        spsr_q[b] <= '0;
      end
      for (int c = 0; c < 2; c++)
        for (int i = 0; i < HI_CNT; i++)
          hi_q[c][i] <= '0;
      elr_q <= '0;
    end else if (wr_en) begin
      case (kind)
        K_SP:    sp_q[bank]           <= wdata;
        K_LR:    lr_q[bank]           <= wdata;
        K_SPSR:  spsr_q[bank]         <= wdata;
        K_HI:    hi_q[hi_fiq][hi_idx] <= wdata;
        K_ELR:   elr_q                <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (kind)
      K_SP:    rdata = sp_q[bank];
      K_LR:    rdata = lr_q[bank];
      K_SPSR:  rdata = spsr_q[bank];
      K_HI:    rdata = hi_q[hi_fiq][hi_idx];
      K_ELR:   rdata = elr_q;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/bnk_regs_top.sv
module bnk_regs_top
  import bnk_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned HI_FIRST  = 8,
  parameter int unsigned HI_CNT    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [4:0]        req_tgt_mode,
  input  logic [4:0]        req_regno,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [4:0]        cur_mode,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              undef_exc
);

  localparam int unsigned HI_IDX_W = (HI_CNT > 1) ? $clog2(HI_CNT) : 1;

  logic                legal;
  slot_kind_t          kind;
  logic [2:0]          bank;
  logic [HI_IDX_W-1:0] hi_idx;
  logic                hi_fiq;
  logic                wr_en;
  logic [DATA_W-1:0]   store_rdata;

  logic              rd_valid_d, undef_d, rd_load;
  logic              rd_valid_q, undef_q;
  logic [DATA_W-1:0] rd_data_q;

  bnk_legal #(.HI_FIRST(HI_FIRST), .HI_CNT(HI_CNT)) u_legal (
    .tgt_mode (req_tgt_mode),
    .regno    (req_regno),
    .cur_mode (cur_mode),
    .legal    (legal),
    .kind     (kind),
    .bank     (bank),
    .hi_idx   (hi_idx),
    .hi_fiq   (hi_fiq)
  );

  bnk_store #(.DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .HI_CNT(HI_CNT)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .kind   (kind),
    .bank   (bank),
    .hi_idx (hi_idx),
    .hi_fiq (hi_fiq),
    .wdata  (req_wdata),
    .rdata  (store_rdata)
  );

  // next state
  always_comb begin
    wr_en      = req_valid && req_write && legal;
    rd_load    = req_valid && !req_write && legal;
    rd_valid_d = rd_load;
    undef_d    = req_valid && !legal;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      undef_q    <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_valid_d;
      undef_q    <= undef_d;
      if (rd_load) rd_data_q <= store_rdata;
    end
  end

  assign rd_valid  = rd_valid_q;
  assign undef_exc = undef_q;
  assign rd_data   = rd_data_q;

endmodule

// File: rtl/bnk_regs_chk.sv
module bnk_regs_chk
  import bnk_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [4:0]        req_tgt_mode,
  input logic [4:0]        req_regno,
  input logic [4:0]        cur_mode,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              undef_exc
);

  // R11
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && undef_exc));

  // R11
  rd_valid_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |=> !rd_valid);

  // R11
  no_req_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rd_valid && !undef_exc);

  // R2
  same_mode_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_tgt_mode == cur_mode) |=> undef_exc);

  // R3
  usr_hi_needs_fiq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_tgt_mode == MODE_USR && req_regno >= 5'd8 &&
    req_regno <= 5'd12 && cur_mode != MODE_FIQ |=> undef_exc);

  // R5
  hyp_needs_mon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_tgt_mode == MODE_HYP && cur_mode != MODE_MON |=> undef_exc);

  // R10
  undef_holds_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef_exc |-> $stable(rd_data));

endmodule

bind bnk_regs_top bnk_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .req_tgt_mode (req_tgt_mode),
  .req_regno    (req_regno),
  .cur_mode     (cur_mode),
  .rd_valid     (rd_valid),
  .rd_data      (rd_data),
  .undef_exc    (undef_exc)
);

// File: tb/tb_bnk_regs_top.sv
`timescale 1ns/1ps
module tb_bnk_regs_top;

  localparam logic [4:0] USR = 5'h10, FIQ = 5'h11, IRQ = 5'h12, SVC = 5'h13,
                         MON = 5'h16, ABT = 5'h17, HYP = 5'h1A, UND = 5'h1B,
                         SYS = 5'h1F;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [4:0]  req_tgt_mode, req_regno, cur_mode;
  logic [31:0] req_wdata;
  logic        rd_valid, undef_exc;
  logic [31:0] rd_data;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  bnk_regs_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_tgt_mode(req_tgt_mode), .req_regno(req_regno), .req_wdata(req_wdata),
    .cur_mode(cur_mode), .rd_valid(rd_valid), .rd_data(rd_data),
    .undef_exc(undef_exc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one request; outputs sampled on the negedge after the capturing edge
  task automatic acc(input logic w, input logic [4:0] tgt, input logic [4:0] rn,
                     input logic [31:0] d, input logic [4:0] cm,
                     output logic v, output logic u, output logic [31:0] q);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_tgt_mode = tgt;
    req_regno = rn; req_wdata = d; cur_mode = cm;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    v = rd_valid; u = undef_exc; q = rd_data;
  endtask

  task automatic wr_ok(input string tag, input logic [4:0] tgt, input logic [4:0] rn,
                       input logic [31:0] d, input logic [4:0] cm);
    logic v, u; logic [31:0] q;
    acc(1'b1, tgt, rn, d, cm, v, u, q);
    chk({tag, " write undef"}, {31'd0, u}, 32'd0);
    chk({tag, " write rd_valid"}, {31'd0, v}, 32'd0);
  endtask

  task automatic rd_ok(input string tag, input logic [4:0] tgt, input logic [4:0] rn,
                       input logic [4:0] cm, input logic [31:0] exp);
    logic v, u; logic [31:0] q;
    acc(1'b0, tgt, rn, 32'd0, cm, v, u, q);
    chk({tag, " read valid"}, {31'd0, v}, 32'd1);
    chk({tag, " read undef"}, {31'd0, u}, 32'd0);
    chk({tag, " read data"}, q, exp);
  endtask

  task automatic bad(input string tag, input logic w, input logic [4:0] tgt,
                     input logic [4:0] rn, input logic [4:0] cm);
    logic v, u; logic [31:0] q;
    acc(w, tgt, rn, 32'hBAD0BAD0, cm, v, u, q);
    chk({tag, " undef"}, {31'd0, u}, 32'd1);
    chk({tag, " rd_valid"}, {31'd0, v}, 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 rd_valid in reset", {31'd0, rd_valid}, 32'd0);
    chk("R1 undef in reset", {31'd0, undef_exc}, 32'd0);
    chk("R1 rd_data in reset", rd_data, 32'd0);
    rst_n = 1'b1;
    rd_ok("R1 irq spsr after reset", IRQ, 5'd16, SVC, 32'd0);
    rd_ok("R1 fiq r12 after reset", FIQ, 5'd12, SVC, 32'd0);
    wr_ok("R1 setup", ABT, 5'd13, 32'h1234_5678, SVC);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_ok("R1 abt sp cleared", ABT, 5'd13, SVC, 32'd0);
  endtask

  task automatic t_same_mode();
    bad("R2 svc->svc sp", 1'b0, SVC, 5'd13, SVC);
    bad("R2 irq->irq spsr", 1'b1, IRQ, 5'd16, IRQ);
    bad("R2 fiq->fiq r9", 1'b0, FIQ, 5'd9, FIQ);
  endtask

  task automatic t_user_hi();
    wr_ok("R3 usr r9 from fiq", USR, 5'd9, 32'hA000_0009, FIQ);
    bad("R3 usr r9 from svc", 1'b1, USR, 5'd9, SVC);
    bad("R3 usr r12 from sys", 1'b0, USR, 5'd12, SYS);
    rd_ok("R3 usr r9 readback", USR, 5'd9, FIQ, 32'hA000_0009);
    wr_ok("R7 fiq r9 from svc", FIQ, 5'd9, 32'hF000_0009, SVC);
    for (int i = 8; i <= 12; i++)
      wr_ok("R7 usr fill", USR, 5'(i), 32'hC000_0000 + 32'(i), FIQ);
    for (int i = 8; i <= 12; i++)
      rd_ok("R7 usr copy", USR, 5'(i), FIQ, 32'hC000_0000 + 32'(i));
    rd_ok("R7 fiq r9 separate", FIQ, 5'd9, IRQ, 32'hF000_0009);
  endtask

  task automatic t_user_sp_lr();
    bad("R4 usr sp from sys", 1'b0, USR, 5'd13, SYS);
    bad("R4 usr lr from sys", 1'b1, USR, 5'd14, SYS);
    bad("R4 usr lr from hyp", 1'b0, USR, 5'd14, HYP);
    wr_ok("R4 usr sp from hyp", USR, 5'd13, 32'h5555_0013, HYP);
    wr_ok("R4 usr lr from svc", USR, 5'd14, 32'h5555_0014, SVC);
    rd_ok("R6 sys sp shares usr bank", SYS, 5'd13, SVC, 32'h5555_0013);
    rd_ok("R6 sys lr shares usr bank", SYS, 5'd14, MON, 32'h5555_0014);
  endtask

  task automatic t_hyp();
    wr_ok("R5 hyp elr from mon", HYP, 5'd17, 32'hE1E1_0017, MON);
    bad("R5 hyp elr from svc", 1'b0, HYP, 5'd17, SVC);
    bad("R5 hyp elr from hyp", 1'b0, HYP, 5'd17, HYP);
    bad("R5 hyp spsr from svc", 1'b1, HYP, 5'd16, SVC);
    bad("R5 hyp sp from irq", 1'b0, HYP, 5'd13, IRQ);
    wr_ok("R5 hyp spsr from mon", HYP, 5'd16, 32'h0000_01DA, MON);
    rd_ok("R8 elr readback", HYP, 5'd17, MON, 32'hE1E1_0017);
    rd_ok("R5 hyp spsr readback", HYP, 5'd16, MON, 32'h0000_01DA);
  endtask

  task automatic t_banks();
    logic [4:0] m [6] = '{FIQ, IRQ, SVC, ABT, UND, MON};
    for (int i = 0; i < 6; i++) begin
      logic [4:0] cm;
      cm = (m[i] == SVC) ? IRQ : SVC;
      wr_ok("R6 spsr fill", m[i], 5'd16, 32'h5B00_0000 + 32'(i), cm);
      wr_ok("R6 sp fill",   m[i], 5'd13, 32'h5D00_0000 + 32'(i), cm);
      wr_ok("R6 lr fill",   m[i], 5'd14, 32'h1E00_0000 + 32'(i), cm);
    end
    for (int i = 0; i < 6; i++) begin
      logic [4:0] cm;
      cm = (m[i] == SVC) ? IRQ : SVC;
      rd_ok("R6 spsr bank", m[i], 5'd16, cm, 32'h5B00_0000 + 32'(i));
      rd_ok("R6 sp bank",   m[i], 5'd13, cm, 32'h5D00_0000 + 32'(i));
      rd_ok("R6 lr bank",   m[i], 5'd14, cm, 32'h1E00_0000 + 32'(i));
    end
  endtask

  task automatic t_unlisted();
    bad("R9 reg 15", 1'b0, IRQ, 5'd15, SVC);
    bad("R9 reg 3", 1'b1, IRQ, 5'd3, SVC);
    bad("R9 reg 18", 1'b0, IRQ, 5'd18, SVC);
    bad("R9 bad target code", 1'b0, 5'h14, 5'd13, SVC);
    bad("R9 r8 irq target", 1'b1, IRQ, 5'd8, SVC);
    bad("R9 spsr usr target", 1'b0, USR, 5'd16, SVC);
    bad("R9 spsr sys target", 1'b1, SYS, 5'd16, SVC);
    bad("R9 elr svc target", 1'b0, SVC, 5'd17, MON);
  endtask

  task automatic t_no_effect();
    wr_ok("R10 setup", IRQ, 5'd13, 32'hAAAA_0001, SVC);
    bad("R10 same-mode write", 1'b1, IRQ, 5'd13, IRQ);
    rd_ok("R10 irq sp kept", IRQ, 5'd13, SVC, 32'hAAAA_0001);
    bad("R10 illegal read", 1'b0, IRQ, 5'd13, IRQ);
    chk("R10 rd_data held", rd_data, 32'hAAAA_0001);
    bad("R10 usr r10 from svc", 1'b1, USR, 5'd10, SVC);
    rd_ok("R10 usr r10 kept", USR, 5'd10, FIQ, 32'hC000_000A);
    bad("R10 elr from svc write", 1'b1, HYP, 5'd17, SVC);
    rd_ok("R10 elr kept", HYP, 5'd17, MON, 32'hE1E1_0017);
  endtask

  task automatic t_timing();
    // request at one edge, result visible only after that edge, gone after the next
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_tgt_mode = UND;
    req_regno = 5'd13; cur_mode = SVC;
    #1 chk("R11 not early", {31'd0, rd_valid}, 32'd0);
    @(negedge clk); req_valid = 1'b0;
    chk("R11 valid after one edge", {31'd0, rd_valid}, 32'd1);
    chk("R11 data after one edge", rd_data, 32'h5D00_0004);
    @(negedge clk);
    chk("R11 valid is a pulse", {31'd0, rd_valid}, 32'd0);
    bad("R11 illegal gives undef only", 1'b0, 5'h00, 5'd13, SVC);
    @(negedge clk);
    chk("R11 undef is a pulse", {31'd0, undef_exc}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_tgt_mode = 5'd0; req_regno = 5'd0; req_wdata = 32'd0; cur_mode = SVC;
    repeat (3) @(negedge clk);
    t_reset();
    t_same_mode();
    t_user_hi();
    t_user_sp_lr();
    t_hyp();
    t_banks();
    t_unlisted();
    t_no_effect();
    t_timing();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired: actual=hung expected=complete");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule